// File: doc/BRIEF.md
# Exclusive Access Monitor

This block sits beside a single memory target and watches its read-address and write-address handshakes so that reservation-style exclusive accesses can be honoured. A locked read arms a per-ID reservation on the size-aligned address it touched. A later locked write from the same ID is allowed to reach memory only if that reservation is still intact. Any write that really updates memory cancels every reservation that covers its address.

For every write-address handshake the block returns one verdict a cycle later. The verdict carries a memory write-enable gate and a 2-bit response code. The response encoding is OKAY = 00, EXOKAY = 01, SLVERR = 10 and DECERR = 11; only the first two are ever produced. The table has one entry per ID value, 2^ID_W entries in all (four by default), and each entry has a valid bit. The address channels are only observed: a handshake counts when valid and ready are both high in a cycle. The block drives neither ready, so it applies no back-pressure. The verdict strobe has no ready and must be consumed in the cycle it appears.

Top module: `excl_monitor`

## Requirements
- R1: A read handshake with the lock flag set arms the entry of its ID, holding the read address with its low `ar_size` bits cleared.
- R2: A later locked read with the same ID moves that entry to the new address, and the old address is no longer reserved for that ID.
- R3: A write that updates memory (`wr_en` = 1) clears every valid entry, of any ID, whose address equals the write's aligned address. This includes the writer's own entry after a successful exclusive write.
- R4: A locked write succeeds when the entry of its ID is valid and holds its aligned address. The verdict is then `wr_en` = 1 and `wr_resp` = 01 (EXOKAY).
- R5: Any other locked write fails, with `wr_en` = 0 and `wr_resp` = 00 (OKAY). A failed write clears no entry.
- R6: A write without the lock flag always gives `wr_en` = 1 and `wr_resp` = 00.
- R7: A read without the lock flag never changes any entry.
- R8: `wr_valid` is high exactly in the cycle after a write-address handshake. `wr_en` and `wr_resp` are 0 whenever `wr_valid` is 0. A write with valid high and ready low produces no verdict.
- R9: Every address compare uses each transfer's own alignment: the address with its low `size` bits cleared, where a transfer is 2^size bytes.
- R10: When a read and a write handshake occur in the same cycle, the write is judged against the entries as they were before that cycle and its clearing is applied first. The locked read then arms its ID's entry, overriding any clear of that entry.
- R11: After reset all entries are invalid, so a locked write fails, and `wr_valid` is 0.
- R12: An armed entry stays armed for any number of idle cycles until it is cleared or moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ar_valid | input | 1 | Read-address valid, observed |
| ar_ready | input | 1 | Read-address ready, observed |
| ar_addr | input | ADDR_W | Read byte address |
| ar_id | input | ID_W | Read transaction ID |
| ar_lock | input | 1 | Read is exclusive |
| ar_size | input | SIZE_W | Log2 of read transfer bytes |
| aw_valid | input | 1 | Write-address valid, observed |
| aw_ready | input | 1 | Write-address ready, observed |
| aw_addr | input | ADDR_W | Write byte address |
| aw_id | input | ID_W | Write transaction ID |
| aw_lock | input | 1 | Write is exclusive |
| aw_size | input | SIZE_W | Log2 of write transfer bytes |
| wr_valid | output | 1 | Verdict strobe, one cycle |
| wr_en | output | 1 | Memory update allowed |
| wr_resp | output | 2 | Response code, 00 OKAY or 01 EXOKAY |

## Verification
The verdict for a write-address handshake is registered, so it appears on the first rising edge after the handshake cycle and lasts for that one cycle only. Entry changes are made on the same edge, so a write handshake in the following cycle already sees them. The bench drives each stimulus on a falling edge and compares all four verdict bits at the next falling edge against a reference table kept in bench functions. This tests exactly that one-cycle latency and the same-cycle read/write ordering. Entry contents are never read directly: they are probed with later locked writes.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01,
    RESP_SLVERR = 2'b10,
    RESP_DECERR = 2'b11
  } resp_e;
endpackage

// File: rtl/excl_entry.sv
// One reservation slot: valid bit plus aligned address.
module excl_entry #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic [ADDR_W-1:0] arm_addr_i,
  input  logic [ADDR_W-1:0] cmp_addr_i,
  input  logic              clr_i,
  output logic              valid_o,
  output logic              hit_o
);
  logic [ADDR_W-1:0] addr_q;

  assign hit_o = valid_o && (addr_q == cmp_addr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      addr_q  <= '0;
    end else if (arm_i) begin
      valid_o <= 1'b1;
      addr_q  <= arm_addr_i;
    end else if (clr_i && hit_o) begin
      valid_o <= 1'b0;
    end
  end

  // R1: arming takes the presented address
  assert_arm_records_R1: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> (valid_o && addr_q == $past(arm_addr_i)));

  // R3: a committed matching write drops the slot unless re-armed
  assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && hit_o && !arm_i) |=> !valid_o);
endmodule

// File: rtl/excl_verdict.sv
// Registers the per-write verdict.
module excl_verdict
  import excl_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire_i,
  input  logic       commit_i,
  input  logic       exok_i,
  output logic       vld_o,
  output logic       en_o,
  output logic [1:0] resp_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      en_o   <= 1'b0;
      resp_o <= RESP_OKAY;
    end else if (fire_i) begin
      vld_o  <= 1'b1;
      en_o   <= commit_i;
      resp_o <= exok_i ? RESP_EXOKAY : RESP_OKAY;
    end else begin
      vld_o  <= 1'b0;
      en_o   <= 1'b0;
      resp_o <= RESP_OKAY;
    end
  end

  // R4: an EXOKAY verdict always lets the write through
  assert_exok_writes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && resp_o == RESP_EXOKAY) |-> en_o);
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 2,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ar_valid,
  input  logic              ar_ready,
  input  logic [ADDR_W-1:0] ar_addr,
  input  logic [ID_W-1:0]   ar_id,
  input  logic              ar_lock,
  input  logic [SIZE_W-1:0] ar_size,
  input  logic              aw_valid,
  input  logic              aw_ready,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic [ID_W-1:0]   aw_id,
  input  logic              aw_lock,
  input  logic [SIZE_W-1:0] aw_size,
  output logic              wr_valid,
  output logic              wr_en,
  output logic [1:0]        wr_resp
);
  localparam int N_ID = 1 << ID_W;

  function automatic logic [ADDR_W-1:0] align_f(input logic [ADDR_W-1:0] a,
                                                input logic [SIZE_W-1:0] s);
    logic [ADDR_W-1:0] m;
    m = '1;
    m = m << s;
    return a & m;
  endfunction

  logic              ar_fire, aw_fire;
  logic [ADDR_W-1:0] ar_key, aw_key;
  logic [N_ID-1:0]   ent_vld, ent_hit;
  logic              own_hit, commit, exok;

  assign ar_fire = ar_valid && ar_ready;
  assign aw_fire = aw_valid && aw_ready;
  assign ar_key  = align_f(ar_addr, ar_size);
  assign aw_key  = align_f(aw_addr, aw_size);
  assign own_hit = ent_hit[aw_id];
  assign commit  = aw_fire && (!aw_lock || own_hit);
  assign exok    = aw_fire && aw_lock && own_hit;

  for (genvar g = 0; g < N_ID; g++) begin : g_ent
    excl_entry #(.ADDR_W(ADDR_W)) u_ent (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm_i      (ar_fire && ar_lock && (ar_id == ID_W'(g))),
      .arm_addr_i (ar_key),
      .cmp_addr_i (aw_key),
      .clr_i      (commit),
      .valid_o    (ent_vld[g]),
      .hit_o      (ent_hit[g])
    );
  end

  excl_verdict u_vrd (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire_i   (aw_fire),
    .commit_i (commit),
    .exok_i   (exok),
    .vld_o    (wr_valid),
    .en_o     (wr_en),
    .resp_o   (wr_resp)
  );

  // R5: failing exclusive write is blocked with OKAY
  assert_fail_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_fire && aw_lock && !own_hit) |=> (wr_valid && !wr_en && wr_resp == 2'b00));

  // R6: plain write passes with OKAY
  assert_plain_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_fire && !aw_lock) |=> (wr_valid && wr_en && wr_resp == 2'b00));

  // R7: plain read alone leaves the table untouched
  assert_plain_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_fire && !ar_lock && !aw_fire) |=> $stable(ent_vld));

  // R8: verdict only after a write handshake
  assert_verdict_timing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !aw_fire |=> !wr_valid);
endmodule

// File: tb/test_excl_monitor.sv
`timescale 1ns/1ps
module test_excl_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ar_valid = 0, ar_ready = 0, ar_lock = 0;
  logic [31:0] ar_addr = 0;
  logic [1:0]  ar_id = 0;
  logic [2:0]  ar_size = 0;
  logic        aw_valid = 0, aw_ready = 0, aw_lock = 0;
  logic [31:0] aw_addr = 0;
  logic [1:0]  aw_id = 0;
  logic [2:0]  aw_size = 0;
  logic        wr_valid, wr_en;
  logic [1:0]  wr_resp;

  int checks = 0;
  int errors = 0;
  logic        mv[4];
  logic [31:0] ma[4];

  always #4 clk = ~clk;

  excl_monitor i_excl_monitor (
    .clk(clk), .rst_n(rst_n),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_id(ar_id),
    .ar_lock(ar_lock), .ar_size(ar_size),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_id(aw_id),
    .aw_lock(aw_lock), .aw_size(aw_size),
    .wr_valid(wr_valid), .wr_en(wr_en), .wr_resp(wr_resp));

  function automatic logic [31:0] align(input logic [31:0] a, input int s);
    return a & (32'hFFFF_FFFF << s);
  endfunction

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got {valid,en,resp}=%b expected %b", tag, got, exp);
    end
  endtask

  // Drive one cycle at a falling edge, update the model, check at the next falling edge.
  task automatic step(input logic arv, input logic arr, input logic arl, input int arid,
                      input logic [31:0] ara, input int ars,
                      input logic awv, input logic awr, input logic awl, input int awid,
                      input logic [31:0] awa, input int aws, input string tag);
    logic [3:0]  exp;
    logic        own, commit;
    logic [31:0] k;
    ar_valid = arv; ar_ready = arr; ar_lock = arl; ar_id = 2'(arid);
    ar_addr = ara; ar_size = 3'(ars);
    aw_valid = awv; aw_ready = awr; aw_lock = awl; aw_id = 2'(awid);
    aw_addr = awa; aw_size = 3'(aws);
    exp = 4'b0000;
    if (awv && awr) begin
      k = align(awa, aws);
      own = mv[awid] && (ma[awid] == k);
      commit = !awl || own;
      exp = {1'b1, commit, 1'b0, awl && own};
      if (commit)
        for (int i = 0; i < 4; i++) if (mv[i] && ma[i] == k) mv[i] = 1'b0;
    end
    if (arv && arr && arl) begin
      mv[arid] = 1'b1;
      ma[arid] = align(ara, ars);
    end
    @(negedge clk);
    check(tag, {wr_valid, wr_en, wr_resp}, exp);
  endtask

  task automatic rd(input logic lk, input int id, input logic [31:0] a, input int s, input string tag);
    step(1, 1, lk, id, a, s, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic wr(input logic lk, input int id, input logic [31:0] a, input int s, input string tag);
    step(0, 0, 0, 0, 0, 0, 1, 1, lk, id, a, s, tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  function automatic logic [31:0] pick_addr(input int r);
    logic [31:0] base;
    case (r % 4)
      0: base = 32'h100;
      1: base = 32'h104;
      2: base = 32'h200;
      default: base = 32'h208;
    endcase
    return base + 32'((r / 4) % 4);
  endfunction

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mv[i] = 1'b0; ma[i] = '0; end
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 reset verdict idle", {wr_valid, wr_en, wr_resp}, 4'b0000);
    wr(1, 0, 32'h100, 2, "R11 locked write after reset fails");

    rd(1, 0, 32'h100, 2, "R1 arm id0");
    wr(1, 0, 32'h100, 2, "R1 R4 exclusive write succeeds");
    wr(1, 0, 32'h100, 2, "R3 own entry cleared after success");

    rd(1, 1, 32'h200, 2, "R2 arm id1");
    rd(1, 1, 32'h300, 2, "R2 retarget id1");
    wr(1, 1, 32'h200, 2, "R2 old address fails");
    wr(1, 1, 32'h300, 2, "R2 new address succeeds");

    rd(1, 2, 32'h400, 2, "R3 arm id2");
    rd(1, 3, 32'h400, 2, "R3 arm id3");
    wr(0, 0, 32'h400, 2, "R6 plain write OKAY");
    wr(1, 2, 32'h400, 2, "R3 id2 cleared by plain write");
    wr(1, 3, 32'h400, 2, "R3 id3 cleared by plain write");

    rd(1, 0, 32'h103, 2, "R9 arm unaligned");
    wr(1, 0, 32'h101, 2, "R9 aligned match succeeds");
    rd(1, 0, 32'h103, 0, "R9 arm byte size");
    wr(1, 0, 32'h100, 2, "R9 different alignment fails");

    rd(1, 1, 32'h500, 2, "R7 arm id1");
    rd(0, 1, 32'h600, 2, "R7 plain read");
    wr(1, 1, 32'h500, 2, "R7 entry unchanged");

    rd(1, 2, 32'h700, 2, "R12 arm id2");
    repeat (50) idle("R12 idle");
    wr(1, 2, 32'h700, 2, "R12 entry still armed");

    rd(1, 3, 32'h800, 2, "R10 arm id3");
    rd(1, 0, 32'h880, 2, "R10 arm id0");
    step(1, 1, 1, 0, 32'h990, 2, 1, 1, 1, 0, 32'h880, 2, "R10 write judged on old state");
    step(1, 1, 1, 3, 32'h800, 2, 1, 1, 0, 1, 32'h800, 2, "R10 plain write plus rearm");
    wr(1, 3, 32'h800, 2, "R10 rearm overrides clear");
    wr(1, 0, 32'h990, 2, "R10 same-cycle read armed");

    rd(1, 0, 32'h900, 2, "R5 arm id0");
    rd(1, 1, 32'h900, 2, "R5 arm id1");
    wr(1, 2, 32'h900, 2, "R5 unarmed id fails");
    wr(1, 0, 32'h900, 2, "R5 failed write cleared nothing");
    wr(1, 1, 32'h900, 2, "R3 success clears other id");

    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 32'h100, 2, "R8 no ready no verdict");
    idle("R8 idle after stall");

    for (int n = 0; n < 3000; n++) begin
      logic arv, arr, arl, awv, awr, awl;
      int arid, awid, ars, aws;
      logic [31:0] ara, awa;
      string tag;
      arv = 1'($urandom); arr = ($urandom % 4) != 0; arl = 1'($urandom);
      arid = int'($urandom % 4); ara = pick_addr(int'($urandom % 64)); ars = int'($urandom % 3);
      awv = ($urandom % 3) != 0; awr = ($urandom % 4) != 0; awl = ($urandom % 3) != 0;
      awid = int'($urandom % 4); awa = pick_addr(int'($urandom % 64)); aws = int'($urandom % 3);
      if (!(awv && awr)) tag = "R8 random no verdict";
      else if (!awl) tag = "R6 random plain write";
      else if (mv[awid] && ma[awid] == align(awa, aws)) tag = "R4 random exclusive pass";
      else tag = "R5 random exclusive fail";
      step(arv, arr, arl, arid, ara, ars, awv, awr, awl, awid, awa, aws, tag);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule